// File: doc/BRIEF.md
# Pipeline Interlock Stall Generator

This block sits beside the fetch and decode stages of a small in-order DSP pipeline. Each cycle it compares the decoded fields of the instruction in decode with those of the instruction one stage ahead, in execute. When the pair forms a hazard that forwarding cannot cover, it raises a stall. The stall freezes fetch and decode, and a bubble enters execute on the next edge. Stages below execute keep moving.

Four hazard classes are detected. The first is a multiply whose two operands were both just produced by the multiplier or the ALU. The second is any instruction that changes a mode register, directly or through the status stack. The third is a return that follows a load of the program-counter stack. The fourth is a follower that reuses an index register that a conditional access has just post-modified. Stalls are chosen only from instruction classes. Whether the preceding access went to a peripheral register, or whether DMA was using the same memory bank, never removes a stall.

The block keeps its own copy of the execute-stage fields, so the surrounding pipeline only supplies the decode-stage fields and a condition-resolved signal.

Top module: `interlock_stall_gen`

## Requirements
- R1: A valid multiply in decode (decIsMul=1) stalls for exactly one cycle when both source ids match an enabled destination of the instruction in execute and that instruction's unit tag is ALU (1) or multiplier (2). A match on only one source, or unit tag none (0) or shifter (3), gives no stall.
- R2: An instruction in execute with a mode-touch code other than 0 stalls the valid instruction behind it for exactly one cycle. The codes are 1 register write, 2 bit operation, 3 status push, 4 status pop, 5 interrupt entry with status save, 6 interrupt return with status restore. Code 0 gives no stall.
- R3: A return in decode (decIsReturn=1) directly behind a program-counter-stack load in execute stalls for exactly one cycle. Neither one on its own causes a stall.
- R4: A conditional post-modify in execute whose condition is internal (decExtFlag=0) stalls for exactly one cycle a follower that uses the same index id. A different index id, or a follower that uses no index, gives no stall.
- R5: When that condition comes from an external flag (decExtFlag=1), the follower stalls until condResolved is seen, for at most SYNC_CYC cycles. With the default of 2, the stall lasts one cycle if condResolved is high in the cycle after the first stall cycle, and two cycles otherwise.
- R6: decIoAccess and dmaBankHit have no effect on the stall in any case.
- R7: Hazards present in the same cycle are ORed. Coincident one-cycle hazards give one stall cycle in total, not one each.
- R8: execBubble is high in exactly the cycle that follows each stall cycle, and low otherwise.
- R9: After reset, stallFront and execBubble are low. A decode slot with decValid=0 never stalls, and an instruction behind an empty execute stage, with no pending flag condition, does not stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| decValid | input | 1 | Decode slot holds a real instruction |
| decSrcA | input | REG_W | First source register id |
| decSrcB | input | REG_W | Second source register id |
| decIsMul | input | 1 | Instruction is a multiply |
| decDstA | input | REG_W | First destination register id |
| decDstB | input | REG_W | Second destination register id |
| decDstAEn | input | 1 | First destination is written |
| decDstBEn | input | 1 | Second destination is written |
| decUnit | input | 2 | Producing unit: 0 none, 1 ALU, 2 multiplier, 3 shifter |
| decModeTouch | input | 3 | Mode-change class code (see R2) |
| decPcStkLoad | input | 1 | Instruction loads the program-counter stack |
| decIsReturn | input | 1 | Subroutine or interrupt return |
| decIdx | input | IDX_W | Index register id |
| decUsesIdx | input | 1 | Instruction addresses through decIdx |
| decCondPostMod | input | 1 | Conditional access that post-modifies decIdx |
| decExtFlag | input | 1 | Condition comes from an external flag |
| decIoAccess | input | 1 | Memory access targets a peripheral register |
| dmaBankHit | input | 1 | DMA is using the same memory bank this cycle |
| condResolved | input | 1 | Pending external flag condition is now resolved |
| stallFront | output | 1 | Freeze fetch and decode this cycle |
| execBubble | output | 1 | Execute stage holds an injected bubble |

## Verification
stallFront is a combinational result of the decode inputs and the stored execute fields. It is due in the same cycle that the follower is presented. The bench drives on the falling edge and samples one nanosecond later, before the next rising edge. execBubble comes from a register and is due one rising edge after each stall cycle, so it is checked after every edge that a stalled follower spends in decode, and once more after the follower issues. For the external-flag case, the bench raises condResolved on the falling edge after the first stall cycle and counts the consecutive stall cycles. Each count is compared with a value computed from the requirements for the instruction pair.

// File: rtl/interlock_pkg.sv
`timescale 1ns/1ps
package interlock_pkg;

  typedef enum logic [1:0] {
    UNIT_NONE = 2'd0,
    UNIT_ALU  = 2'd1,
    UNIT_MUL  = 2'd2,
    UNIT_SHF  = 2'd3
  } unitTag_e;

  typedef enum logic [2:0] {
    MT_NONE       = 3'd0,
    MT_REG_WRITE  = 3'd1,
    MT_BIT_OP     = 3'd2,
    MT_STAT_PUSH  = 3'd3,
    MT_STAT_POP   = 3'd4,
    MT_IRQ_ENTER  = 3'd5,
    MT_IRQ_RETURN = 3'd6
  } modeTouch_e;

  // Strobes from control to the datapath registers.
  typedef struct packed {
    logic loadExec;      // move decode fields into execute
    logic injectBubble;  // execute becomes empty (stall)
    logic capturePend;   // record an external-flag conditional index update
    logic clearPend;     // drop the pending record
    logic advancePend;   // age the pending record
  } dpStrobe_t;

  localparam int NUM_HAZ = 5;

endpackage

// File: rtl/interlock_dp.sv
`timescale 1ns/1ps
module interlock_dp
  import interlock_pkg::*;
#(
  parameter int REG_W    = 4,
  parameter int IDX_W    = 3,
  parameter int SYNC_CYC = 2,
  localparam int CNT_W   = $clog2(SYNC_CYC + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  input  logic             decValid,
  input  logic [REG_W-1:0] decDstA,
  input  logic [REG_W-1:0] decDstB,
  input  logic             decDstAEn,
  input  logic             decDstBEn,
  input  logic [1:0]       decUnit,
  input  logic [2:0]       decModeTouch,
  input  logic             decPcStkLoad,
  input  logic [IDX_W-1:0] decIdx,
  input  logic             decCondPostMod,
  input  logic             decExtFlag,
  output logic             exValid,
  output logic [REG_W-1:0] exDstA,
  output logic [REG_W-1:0] exDstB,
  output logic             exDstAEn,
  output logic             exDstBEn,
  output unitTag_e         exUnit,
  output modeTouch_e       exModeTouch,
  output logic             exPcStkLoad,
  output logic [IDX_W-1:0] exIdx,
  output logic             exCondPostMod,
  output logic             exExtFlag,
  output logic             pendValid,
  output logic [IDX_W-1:0] pendIdx,
  output logic             pendLast,
  output logic             bubbleR
);

  logic [CNT_W-1:0] pendCnt;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(SYNC_CYC - 1);

  // Execute-stage copy of the instruction ahead of decode.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      exValid       <= 1'b0;
      exDstA        <= '0;
      exDstB        <= '0;
      exDstAEn      <= 1'b0;
      exDstBEn      <= 1'b0;
      exUnit        <= UNIT_NONE;
      exModeTouch   <= MT_NONE;
      exPcStkLoad   <= 1'b0;
      exIdx         <= '0;
      exCondPostMod <= 1'b0;
      exExtFlag     <= 1'b0;
    end else if (strobe.loadExec) begin
      exValid       <= decValid;
      exDstA        <= decDstA;
      exDstB        <= decDstB;
      exDstAEn      <= decDstAEn;
      exDstBEn      <= decDstBEn;
      exUnit        <= unitTag_e'(decUnit);
      exModeTouch   <= modeTouch_e'(decModeTouch);
      exPcStkLoad   <= decPcStkLoad;
      exIdx         <= decIdx;
      exCondPostMod <= decCondPostMod;
      exExtFlag     <= decExtFlag;
    end else if (strobe.injectBubble) begin
      exValid       <= 1'b0;
      exDstAEn      <= 1'b0;
      exDstBEn      <= 1'b0;
      exModeTouch   <= MT_NONE;
      exPcStkLoad   <= 1'b0;
      exCondPostMod <= 1'b0;
      exExtFlag     <= 1'b0;
    end
  end

  // Bubble marker seen by the execute stage.
  always_ff @(posedge clk) begin
    if (!rstN) bubbleR <= 1'b0;
    else       bubbleR <= strobe.injectBubble;
  end

  // Record of a conditional index update whose flag is still settling.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendValid <= 1'b0;
      pendIdx   <= '0;
      pendCnt   <= '0;
    end else if (strobe.capturePend) begin
      pendValid <= 1'b1;
      pendIdx   <= exIdx;
      pendCnt   <= CNT_W'(1);
    end else if (strobe.clearPend) begin
      pendValid <= 1'b0;
      pendCnt   <= '0;
    end else if (strobe.advancePend) begin
      pendCnt   <= pendCnt + CNT_W'(1);
    end
  end

  assign pendLast = (pendCnt >= LAST_CNT);

endmodule

// File: rtl/interlock_ctrl.sv
`timescale 1ns/1ps
module interlock_ctrl
  import interlock_pkg::*;
#(
  parameter int REG_W = 4,
  parameter int IDX_W = 3
) (
  input  logic             decValid,
  input  logic [REG_W-1:0] decSrcA,
  input  logic [REG_W-1:0] decSrcB,
  input  logic             decIsMul,
  input  logic             decIsReturn,
  input  logic [IDX_W-1:0] decIdx,
  input  logic             decUsesIdx,
  input  logic             condResolved,
  input  logic             exValid,
  input  logic [REG_W-1:0] exDstA,
  input  logic [REG_W-1:0] exDstB,
  input  logic             exDstAEn,
  input  logic             exDstBEn,
  input  unitTag_e         exUnit,
  input  modeTouch_e       exModeTouch,
  input  logic             exPcStkLoad,
  input  logic [IDX_W-1:0] exIdx,
  input  logic             exCondPostMod,
  input  logic             exExtFlag,
  input  logic             pendValid,
  input  logic [IDX_W-1:0] pendIdx,
  input  logic             pendLast,
  output logic             stall,
  output dpStrobe_t        strobe
);

  localparam int NUM_SRC = 2;

  logic [REG_W-1:0]   srcId [NUM_SRC];
  logic [NUM_SRC-1:0] srcHit;
  logic [NUM_HAZ-1:0] hazVec;
  logic               producerFeedsMul;

  assign srcId[0] = decSrcA;
  assign srcId[1] = decSrcB;

  for (genvar g = 0; g < NUM_SRC; g++) begin : gSrc
    assign srcHit[g] = (exDstAEn && (srcId[g] == exDstA)) ||
                       (exDstBEn && (srcId[g] == exDstB));
  end

  assign producerFeedsMul = (exUnit == UNIT_ALU) || (exUnit == UNIT_MUL);

  always_comb begin
    hazVec    = '0;
    // multiply needing both operands from the instruction just ahead
    hazVec[0] = decIsMul && exValid && producerFeedsMul && (&srcHit);
    // any mode-register change, direct or through the status stack
    hazVec[1] = exValid && (exModeTouch != MT_NONE);
    // return behind a program-counter-stack load
    hazVec[2] = exValid && exPcStkLoad && decIsReturn;
    // follower reusing a conditionally post-modified index
    hazVec[3] = exValid && exCondPostMod && decUsesIdx && (decIdx == exIdx);
    // external flag condition still settling
    hazVec[4] = pendValid && !condResolved && decUsesIdx && (decIdx == pendIdx);
  end

  assign stall = decValid && (|hazVec);

  always_comb begin
    strobe              = '0;
    strobe.loadExec     = !stall;
    strobe.injectBubble = stall;
    strobe.capturePend  = exValid && exCondPostMod && exExtFlag;
    strobe.clearPend    = pendValid && (condResolved || pendLast);
    strobe.advancePend  = pendValid;
  end

endmodule

// File: rtl/interlock_stall_gen.sv
`timescale 1ns/1ps
module interlock_stall_gen
  import interlock_pkg::*;
#(
  parameter int REG_W    = 4,
  parameter int IDX_W    = 3,
  parameter int SYNC_CYC = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             decValid,
  input  logic [REG_W-1:0] decSrcA,
  input  logic [REG_W-1:0] decSrcB,
  input  logic             decIsMul,
  input  logic [REG_W-1:0] decDstA,
  input  logic [REG_W-1:0] decDstB,
  input  logic             decDstAEn,
  input  logic             decDstBEn,
  input  logic [1:0]       decUnit,
  input  logic [2:0]       decModeTouch,
  input  logic             decPcStkLoad,
  input  logic             decIsReturn,
  input  logic [IDX_W-1:0] decIdx,
  input  logic             decUsesIdx,
  input  logic             decCondPostMod,
  input  logic             decExtFlag,
  input  logic             decIoAccess,
  input  logic             dmaBankHit,
  input  logic             condResolved,
  output logic             stallFront,
  output logic             execBubble
);

  dpStrobe_t        strobe;
  logic             exValid, exDstAEn, exDstBEn, exPcStkLoad;
  logic             exCondPostMod, exExtFlag, pendValid, pendLast;
  logic [REG_W-1:0] exDstA, exDstB;
  logic [IDX_W-1:0] exIdx, pendIdx;
  unitTag_e         exUnit;
  modeTouch_e       exModeTouch;

  // Data source and bank activity play no part in the decision.
  logic unusedSideInfo;
  assign unusedSideInfo = decIoAccess ^ dmaBankHit;

  interlock_ctrl #(.REG_W(REG_W), .IDX_W(IDX_W)) ctrl_i (
    .decValid      (decValid),
    .decSrcA       (decSrcA),
    .decSrcB       (decSrcB),
    .decIsMul      (decIsMul),
    .decIsReturn   (decIsReturn),
    .decIdx        (decIdx),
    .decUsesIdx    (decUsesIdx),
    .condResolved  (condResolved),
    .exValid       (exValid),
    .exDstA        (exDstA),
    .exDstB        (exDstB),
    .exDstAEn      (exDstAEn),
    .exDstBEn      (exDstBEn),
    .exUnit        (exUnit),
    .exModeTouch   (exModeTouch),
    .exPcStkLoad   (exPcStkLoad),
    .exIdx         (exIdx),
    .exCondPostMod (exCondPostMod),
    .exExtFlag     (exExtFlag),
    .pendValid     (pendValid),
    .pendIdx       (pendIdx),
    .pendLast      (pendLast),
    .stall         (stallFront),
    .strobe        (strobe)
  );

  interlock_dp #(.REG_W(REG_W), .IDX_W(IDX_W), .SYNC_CYC(SYNC_CYC)) dp_i (
    .clk            (clk),
    .rstN           (rstN),
    .strobe         (strobe),
    .decValid       (decValid),
    .decDstA        (decDstA),
    .decDstB        (decDstB),
    .decDstAEn      (decDstAEn),
    .decDstBEn      (decDstBEn),
    .decUnit        (decUnit),
    .decModeTouch   (decModeTouch),
    .decPcStkLoad   (decPcStkLoad),
    .decIdx         (decIdx),
    .decCondPostMod (decCondPostMod),
    .decExtFlag     (decExtFlag),
    .exValid        (exValid),
    .exDstA         (exDstA),
    .exDstB         (exDstB),
    .exDstAEn       (exDstAEn),
    .exDstBEn       (exDstBEn),
    .exUnit         (exUnit),
    .exModeTouch    (exModeTouch),
    .exPcStkLoad    (exPcStkLoad),
    .exIdx          (exIdx),
    .exCondPostMod  (exCondPostMod),
    .exExtFlag      (exExtFlag),
    .pendValid      (pendValid),
    .pendIdx        (pendIdx),
    .pendLast       (pendLast),
    .bubbleR        (execBubble)
  );

endmodule

// File: rtl/interlock_stall_gen_chk.sv
`timescale 1ns/1ps
module interlock_stall_gen_chk #(
  parameter int REG_W    = 4,
  parameter int IDX_W    = 3,
  parameter int SYNC_CYC = 2
) (
  input logic             clk,
  input logic             rstN,
  input logic             decValid,
  input logic [REG_W-1:0] decSrcA,
  input logic [REG_W-1:0] decSrcB,
  input logic             decIsMul,
  input logic [REG_W-1:0] decDstA,
  input logic [REG_W-1:0] decDstB,
  input logic             decDstAEn,
  input logic             decDstBEn,
  input logic [1:0]       decUnit,
  input logic [2:0]       decModeTouch,
  input logic             decPcStkLoad,
  input logic             decIsReturn,
  input logic [IDX_W-1:0] decIdx,
  input logic             decUsesIdx,
  input logic             decCondPostMod,
  input logic             decExtFlag,
  input logic             decIoAccess,
  input logic             dmaBankHit,
  input logic             condResolved,
  input logic             stallFront,
  input logic             execBubble
);

  localparam int RUN_W = $clog2(SYNC_CYC + 2);

  logic             pastOk, prevIssued, prevDstAEn, prevDstBEn, prevPcl;
  logic             prevStall;
  logic [REG_W-1:0] prevDstA, prevDstB;
  logic [1:0]       prevUnit;
  logic [2:0]       prevMt;
  logic [RUN_W-1:0] stallRun;
  logic             hitA, hitB;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pastOk     <= 1'b0;
      prevIssued <= 1'b0;
      prevDstAEn <= 1'b0;
      prevDstBEn <= 1'b0;
      prevPcl    <= 1'b0;
      prevStall  <= 1'b0;
      prevDstA   <= '0;
      prevDstB   <= '0;
      prevUnit   <= '0;
      prevMt     <= '0;
      stallRun   <= '0;
    end else begin
      pastOk     <= 1'b1;
      prevIssued <= decValid && !stallFront;
      prevDstAEn <= decDstAEn;
      prevDstBEn <= decDstBEn;
      prevPcl    <= decPcStkLoad;
      prevStall  <= stallFront;
      prevDstA   <= decDstA;
      prevDstB   <= decDstB;
      prevUnit   <= decUnit;
      prevMt     <= decModeTouch;
      if (!stallFront)                    stallRun <= '0;
      else if (stallRun != {RUN_W{1'b1}}) stallRun <= stallRun + RUN_W'(1);
    end
  end

  assign hitA = (prevDstAEn && decSrcA == prevDstA) || (prevDstBEn && decSrcA == prevDstB);
  assign hitB = (prevDstAEn && decSrcB == prevDstA) || (prevDstBEn && decSrcB == prevDstB);

  AST_MUL_BOTH_OPERANDS: assert property (@(posedge clk) disable iff (!rstN)
    (pastOk && prevIssued && (prevUnit == 2'd1 || prevUnit == 2'd2) &&
     decValid && decIsMul && hitA && hitB) |-> stallFront); // R1

  AST_MODE_CHANGE_STALL: assert property (@(posedge clk) disable iff (!rstN)
    (pastOk && prevIssued && prevMt != 3'd0 && decValid) |-> stallFront); // R2

  AST_RETURN_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (pastOk && prevIssued && prevPcl && decValid && decIsReturn) |-> stallFront); // R3

  AST_STALL_BOUNDED: assert property (@(posedge clk) disable iff (!rstN)
    stallFront |-> (stallRun < RUN_W'(SYNC_CYC))); // R5

  AST_BUBBLE_TRACKS_STALL: assert property (@(posedge clk) disable iff (!rstN)
    pastOk |-> (execBubble == prevStall)); // R8

  AST_IDLE_NO_STALL: assert property (@(posedge clk) disable iff (!rstN)
    !decValid |-> !stallFront); // R9

  AST_NO_BUBBLE_AFTER_RESET: assert property (@(posedge clk) disable iff (!rstN)
    !pastOk |-> !execBubble); // R9

  logic unusedChkInputs;
  assign unusedChkInputs = ^{decCondPostMod, decExtFlag, decIoAccess, dmaBankHit,
                             condResolved, decIdx, decUsesIdx};

endmodule

bind interlock_stall_gen interlock_stall_gen_chk #(
  .REG_W(REG_W), .IDX_W(IDX_W), .SYNC_CYC(SYNC_CYC)
) chk_i (.*);

// File: tb/interlock_stall_gen_tb_top.sv
`timescale 1ns/1ps
module interlock_stall_gen_tb_top;

  typedef struct packed {
    logic       v;
    logic [3:0] sa, sb, da, db;
    logic       dae, dbe, mul;
    logic [1:0] unit;
    logic [2:0] mt;
    logic       pcl, ret;
    logic [2:0] idx;
    logic       usesIdx, cpm, ext, io;
  } ins_t;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       decValid = 1'b0, decIsMul = 1'b0, decDstAEn = 1'b0, decDstBEn = 1'b0;
  logic [3:0] decSrcA = '0, decSrcB = '0, decDstA = '0, decDstB = '0;
  logic [1:0] decUnit = '0;
  logic [2:0] decModeTouch = '0, decIdx = '0;
  logic       decPcStkLoad = 1'b0, decIsReturn = 1'b0, decUsesIdx = 1'b0;
  logic       decCondPostMod = 1'b0, decExtFlag = 1'b0, decIoAccess = 1'b0;
  logic       dmaBankHit = 1'b0, condResolved = 1'b0;
  logic       stallFront, execBubble;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  interlock_stall_gen #(.REG_W(4), .IDX_W(3), .SYNC_CYC(2)) dut_i (
    .clk(clk), .rstN(rstN), .decValid(decValid), .decSrcA(decSrcA), .decSrcB(decSrcB),
    .decIsMul(decIsMul), .decDstA(decDstA), .decDstB(decDstB), .decDstAEn(decDstAEn),
    .decDstBEn(decDstBEn), .decUnit(decUnit), .decModeTouch(decModeTouch),
    .decPcStkLoad(decPcStkLoad), .decIsReturn(decIsReturn), .decIdx(decIdx),
    .decUsesIdx(decUsesIdx), .decCondPostMod(decCondPostMod), .decExtFlag(decExtFlag),
    .decIoAccess(decIoAccess), .dmaBankHit(dmaBankHit), .condResolved(condResolved),
    .stallFront(stallFront), .execBubble(execBubble)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic drive(input ins_t x);
    decValid = x.v;   decSrcA = x.sa;  decSrcB = x.sb;  decDstA = x.da;  decDstB = x.db;
    decDstAEn = x.dae; decDstBEn = x.dbe; decIsMul = x.mul; decUnit = x.unit;
    decModeTouch = x.mt; decPcStkLoad = x.pcl; decIsReturn = x.ret; decIdx = x.idx;
    decUsesIdx = x.usesIdx; decCondPostMod = x.cpm; decExtFlag = x.ext; decIoAccess = x.io;
  endtask

  function automatic ins_t blank();
    ins_t x = '0;
    x.v  = 1'b1;
    x.sa = 4'd9; x.sb = 4'd10; x.da = 4'd11; x.db = 4'd12;
    x.idx = 3'd7;
    return x;
  endfunction

  // Expected stall length computed from the requirements.
  function automatic int expCycles(input ins_t a, input ins_t b, input logic resNext);
    logic hA, hB, mulH, modeH, retH, idxH;
    if (!a.v || !b.v) return 0;
    hA    = (a.dae && b.sa == a.da) || (a.dbe && b.sa == a.db);
    hB    = (a.dae && b.sb == a.da) || (a.dbe && b.sb == a.db);
    mulH  = b.mul && (a.unit == 2'd1 || a.unit == 2'd2) && hA && hB;   // R1
    modeH = (a.mt != 3'd0);                                           // R2
    retH  = a.pcl && b.ret;                                           // R3
    idxH  = a.cpm && b.usesIdx && (a.idx == b.idx);                   // R4
    if (idxH && a.ext && !resNext) return 2;                          // R5
    return (mulH || modeH || retH || idxH) ? 1 : 0;                   // R7
  endfunction

  task automatic runPair(input ins_t a, input ins_t b, input logic resNext,
                         input logic dma, input string tag);
    int n;
    int exp;
    ins_t idle = '0;
    exp = expCycles(a, b, resNext);
    repeat (3) begin
      @(negedge clk); drive(idle); dmaBankHit = 1'b0; condResolved = 1'b0;
    end
    @(negedge clk); drive(a); #1;
    check(stallFront == 1'b0, "R9 empty execute", stallFront, 0);
    @(posedge clk);
    @(negedge clk); drive(b); dmaBankHit = dma; condResolved = 1'b0; #1;
    check(execBubble == 1'b0, "R8 no bubble", execBubble, 0);
    n = 0;
    while (stallFront === 1'b1 && n < 5) begin
      n++;
      @(posedge clk);
      @(negedge clk); condResolved = resNext; #1;
      check(execBubble == 1'b1, "R8 bubble after stall", execBubble, 1);
    end
    check(n == exp, tag, n, exp);
    @(posedge clk);
    @(negedge clk); drive(idle); dmaBankHit = 1'b0; condResolved = 1'b0; #1;
    check(execBubble == 1'b0, "R8 bubble cleared", execBubble, 0);
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL R8 watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    ins_t a, b;
    repeat (3) @(posedge clk);
    #1;
    check(stallFront == 1'b0, "R9 reset stall", stallFront, 0);
    check(execBubble == 1'b0, "R9 reset bubble", execBubble, 0);
    @(negedge clk); rstN = 1'b1;

    // R1: multiply operand sweep
    for (int u = 0; u < 4; u++)
      for (int sA = 0; sA < 3; sA++)
        for (int sB = 0; sB < 3; sB++)
          for (int m = 0; m < 2; m++)
            for (int be = 0; be < 2; be++) begin
              a = blank(); a.da = 4'd1; a.db = 4'd2; a.dae = 1'b1; a.dbe = be[0];
              a.unit = u[1:0];
              b = blank(); b.mul = m[0];
              b.sa = (sA == 0) ? 4'd1 : (sA == 1) ? 4'd2 : 4'd5;
              b.sb = (sB == 0) ? 4'd1 : (sB == 1) ? 4'd2 : 4'd5;
              runPair(a, b, 1'b0, 1'b0, "R1 multiply interlock");
            end

    // R2: every mode-touch code
    for (int c = 0; c < 8; c++) begin
      a = blank(); a.mt = c[2:0];
      b = blank();
      runPair(a, b, 1'b0, 1'b0, "R2 mode change");
    end

    // R3: stack load and return combinations
    for (int p = 0; p < 2; p++)
      for (int r = 0; r < 2; r++) begin
        a = blank(); a.pcl = p[0]; a.ret = r[0];
        b = blank(); b.ret = r[0]; b.pcl = p[0] & ~r[0];
        runPair(a, b, 1'b0, 1'b0, "R3 return after stack load");
      end

    // R4: conditional index update, internal condition
    for (int c = 0; c < 2; c++)
      for (int ui = 0; ui < 2; ui++)
        for (int s = 0; s < 2; s++) begin
          a = blank(); a.cpm = c[0]; a.usesIdx = 1'b1; a.idx = 3'd3;
          b = blank(); b.usesIdx = ui[0]; b.idx = s[0] ? 3'd3 : 3'd4;
          runPair(a, b, 1'b0, 1'b0, "R4 index reuse");
        end

    // R5: external flag condition, resolved early or late, same or other index
    for (int s = 0; s < 2; s++)
      for (int r = 0; r < 2; r++) begin
        a = blank(); a.cpm = 1'b1; a.ext = 1'b1; a.usesIdx = 1'b1; a.idx = 3'd2;
        b = blank(); b.usesIdx = 1'b1; b.idx = s[0] ? 3'd2 : 3'd6;
        runPair(a, b, r[0], 1'b0, "R5 external flag");
      end

    // R6: peripheral access and bank conflict over several hazard classes
    for (int k = 0; k < 4; k++)
      for (int sb = 0; sb < 4; sb++) begin
        a = blank(); a.io = sb[0];
        b = blank();
        case (k)
          0: a.mt = 3'd1;
          1: begin a.unit = 2'd2; a.da = 4'd1; a.dae = 1'b1; b.mul = 1'b1;
                   b.sa = 4'd1; b.sb = 4'd1; end
          2: begin a.pcl = 1'b1; b.ret = 1'b1; end
          default: ;
        endcase
        runPair(a, b, 1'b0, sb[1], "R6 data source ignored");
      end

    // R7: coincident hazards
    a = blank(); a.mt = 3'd3; a.pcl = 1'b1; a.unit = 2'd1; a.da = 4'd4; a.dae = 1'b1;
    a.cpm = 1'b1; a.idx = 3'd1;
    b = blank(); b.ret = 1'b1; b.mul = 1'b1; b.sa = 4'd4; b.sb = 4'd4;
    b.usesIdx = 1'b1; b.idx = 3'd1;
    runPair(a, b, 1'b0, 1'b0, "R7 hazards ORed");
    a.ext = 1'b1;
    runPair(a, b, 1'b0, 1'b0, "R7 hazards ORed with flag");
    runPair(a, b, 1'b1, 1'b1, "R7 hazards ORed flag resolved");

    // R9: empty decode slot behind every hazard source
    a = blank(); a.mt = 3'd2; a.pcl = 1'b1; a.cpm = 1'b1; a.ext = 1'b1;
    b = '0; b.ret = 1'b1; b.usesIdx = 1'b1; b.idx = a.idx;
    runPair(a, b, 1'b0, 1'b0, "R9 idle slot");

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule